// File: doc/BRIEF.md
# SDRAM Power-On Bring-Up Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-up to its idle state. After reset it keeps the clock enable high and the command pins at no-operation for a programmable settling interval. It then closes every bank with one precharge. Next it runs a programmable number of auto-refresh cycles, never fewer than eight. It ends by loading the mode register with a 14-bit value taken from an input. Each command is held apart from the next by its recovery time. A lockout follows the mode load, and then a sticky ready flag rises.

Every output comes from a register. A controller that owns the same pins afterwards can wait for the ready flag and then take over the bus. Reset at any point restarts the whole sequence from the settling interval.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs show no-operation ({cs_n,ras_n,cas_n,we_n}=4'b0111), address zero, ready low, clock enable high and every byte-mask bit high.
- R2: The bus holds no-operation until the WAIT_CYCLES-th rising edge after reset is released. That edge places a precharge (4'b0010) on the bus with address bit 10 high and every other address bit low.
- R3: The first auto-refresh (4'b0001, address zero) appears exactly TRP_CYCLES rising edges after the precharge.
- R4: The block issues exactly max(NUM_REFRESH,8) auto-refresh commands, with consecutive ones exactly TRFC_CYCLES edges apart.
- R5: The mode-register load (4'b0000) appears exactly TRFC_CYCLES edges after the last refresh, with the address carrying mode_val.
- R6: The ready flag rises exactly max(TMRD_CYCLES,2) edges after the mode-register load, and only no-operation is driven between the two.
- R7: Once the ready flag is high, it stays high and the bus stays at no-operation until reset.
- R8: Each command lasts one cycle. Every cycle without a scheduled command shows no-operation with address zero.
- R9: Clock enable is high and all byte-mask outputs are high in every cycle.
- R10: Asserting reset partway through the sequence returns the outputs to the R1 state, and the full sequence then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_val | input | ADDR_W | Value placed on the address bus with the mode-register load |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | DQM_W | Byte-mask outputs, held high |
| init_done | output | 1 | Sticky ready flag |

## Verification
Each command and the ready flag come from one output register, so each appears right after the rising edge that issues it. The schedule is fully arithmetic: precharge at edge W, refresh i at W+T+i·F, mode load at W+T+R·F, ready from W+T+R·F+M onward. The bench counts the edges since reset release and samples every output on the falling edge. It then compares the whole bus in every cycle against this schedule, so both early and late commands fail. Two instances run side by side. One has parameters below the minimums, which checks that the refresh count and lockout are raised. The bench repeats the sequence with several mode values and once aborts it with a mid-sequence reset.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef logic [3:0] cmd_t; // {cs_n, ras_n, cas_n, we_n}

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_REF = 4'b0001;
  localparam cmd_t CMD_MRS = 4'b0000;

  localparam int ALL_BANKS_BIT = 10;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MRS_WAIT,
    ST_READY
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_init_timer.sv
module sdr_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CNT_W'(RST_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
  import sdr_init_pkg::*;
#(
  parameter int SETTLE = 20000,
  parameter int TRP    = 3,
  parameter int TRFC   = 7,
  parameter int NREF   = 8,
  parameter int TMRD   = 2
) (
  input  logic clk,
  input  logic rst,
  output cmd_t issue,
  output logic ready_set
);

  localparam int MAXCNT = imax(imax(SETTLE, TRP), imax(TRFC, TMRD));
  localparam int CNT_W  = $clog2(MAXCNT + 1);
  localparam int RC_W   = $clog2(NREF + 1);

  seq_state_t       state_q, state_d;
  logic [RC_W-1:0]  refs_left_q, refs_left_d;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  sdr_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(SETTLE - 1)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  always_comb begin
    state_d     = state_q;
    refs_left_d = refs_left_q;
    issue       = CMD_NOP;
    ready_set   = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    unique case (state_q)
      ST_SETTLE: if (tmr_expired) begin
        issue    = CMD_PRE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TRP - 1);
        state_d  = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (tmr_expired) begin
        issue       = CMD_REF;
        tmr_load    = 1'b1;
        tmr_val     = CNT_W'(TRFC - 1);
        refs_left_d = RC_W'(NREF - 1);
        state_d     = ST_REF_WAIT;
      end
      ST_REF_WAIT: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (refs_left_q == '0) begin
          issue   = CMD_MRS;
          tmr_val = CNT_W'(TMRD - 1);
          state_d = ST_MRS_WAIT;
        end else begin
          issue       = CMD_REF;
          tmr_val     = CNT_W'(TRFC - 1);
          refs_left_d = refs_left_q - 1'b1;
        end
      end
      ST_MRS_WAIT: if (tmr_expired) begin
        ready_set = 1'b1;
        state_d   = ST_READY;
      end
      ST_READY: ;
      default: state_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SETTLE;
      refs_left_q <= '0;
    end else begin
      state_q     <= state_d;
      refs_left_q <= refs_left_d;
    end
  end

endmodule

// File: rtl/sdr_init_pins.sv
module sdr_init_pins
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DQM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              issue,
  input  logic              ready_set,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              done
);

  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << ALL_BANKS_BIT;

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (issue)
      CMD_PRE: addr_d = PRE_ADDR;
      CMD_MRS: addr_d = mode_val;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke  <= 1'b1;
      cmd  <= CMD_NOP;
      addr <= '0;
      dqm  <= '1;
      done <= 1'b0;
    end else begin
      cke  <= 1'b1;
      cmd  <= issue;
      addr <= addr_d;
      dqm  <= '1;
      done <= done | ready_set;
    end
  end

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdr_init_pkg::*;
#(
  parameter int WAIT_CYCLES = 20000,
  parameter int TRP_CYCLES  = 3,
  parameter int TRFC_CYCLES = 7,
  parameter int NUM_REFRESH = 8,
  parameter int TMRD_CYCLES = 2,
  parameter int ADDR_W      = 14,
  parameter int DQM_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int SETTLE_EFF = imax(WAIT_CYCLES, 1);
  localparam int TRP_EFF    = imax(TRP_CYCLES, 1);
  localparam int TRFC_EFF   = imax(TRFC_CYCLES, 1);
  localparam int NREF_EFF   = imax(NUM_REFRESH, 8);
  localparam int TMRD_EFF   = imax(TMRD_CYCLES, 2);

  cmd_t issue, cmd;
  logic ready_set;

  sdr_init_fsm #(
    .SETTLE(SETTLE_EFF),
    .TRP   (TRP_EFF),
    .TRFC  (TRFC_EFF),
    .NREF  (NREF_EFF),
    .TMRD  (TMRD_EFF)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .ready_set(ready_set)
  );

  sdr_init_pins #(
    .ADDR_W(ADDR_W),
    .DQM_W (DQM_W)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .ready_set(ready_set),
    .mode_val (mode_val),
    .cke      (sd_cke),
    .cmd      (cmd),
    .addr     (sd_addr),
    .dqm      (sd_dqm),
    .done     (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdr_init_chk.sv
module sdr_init_chk #(
  parameter int ADDR_W = 14,
  parameter int DQM_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done
);

  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R8: only the four sequence commands ever reach the bus
  a_r8_cmd_legal: assert property (@(posedge clk) disable iff (rst)
    c == 4'b0111 || c == 4'b0010 || c == 4'b0001 || c == 4'b0000);

  // R8: a command is followed by no-operation
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    c != 4'b0111 |=> c == 4'b0111);

  // R9
  a_r9_pins_high: assert property (@(posedge clk) disable iff (rst)
    sd_cke && (&sd_dqm));

  // R2: precharge closes all banks
  a_r2_pre_all: assert property (@(posedge clk) disable iff (rst)
    c == 4'b0010 |-> sd_addr[10]);

  // R7
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r7_quiet_after: assert property (@(posedge clk) disable iff (rst)
    init_done |-> c == 4'b0111);

  // R6: lockout of at least two no-operation cycles before ready
  a_r6_lockout: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> c == 4'b0111 && $past(c) == 4'b0111);

endmodule

bind sdram_bringup_seq sdr_init_chk #(
  .ADDR_W(ADDR_W),
  .DQM_W (DQM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sd_cke   (sd_cke),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_dqm   (sd_dqm),
  .init_done(init_done)
);

// File: tb/sdram_bringup_seq_tb_top.sv
module sdram_bringup_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  // configuration A: plain values
  localparam int A_W = 20, A_T = 3, A_F = 5, A_R = 8, A_M = 2;
  // configuration B: refresh count and lockout below the minimums
  localparam int B_W = 12, B_T = 2, B_F = 4, B_R = 3, B_M = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] mode_a = '0, mode_b = '0;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [13:0] a_addr;
  logic [1:0]  a_dqm;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [13:0] b_addr;
  logic [1:0]  b_dqm;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bringup_seq #(
    .WAIT_CYCLES(A_W), .TRP_CYCLES(A_T), .TRFC_CYCLES(A_F),
    .NUM_REFRESH(A_R), .TMRD_CYCLES(A_M), .ADDR_W(14), .DQM_W(2)
  ) dut_i (
    .clk(clk), .rst(rst), .mode_val(mode_a), .sd_cke(a_cke),
    .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_addr(a_addr), .sd_dqm(a_dqm), .init_done(a_done)
  );

  sdram_bringup_seq #(
    .WAIT_CYCLES(B_W), .TRP_CYCLES(B_T), .TRFC_CYCLES(B_F),
    .NUM_REFRESH(B_R), .TMRD_CYCLES(B_M), .ADDR_W(14), .DQM_W(2)
  ) dut_b (
    .clk(clk), .rst(rst), .mode_val(mode_b), .sd_cke(b_cke),
    .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_addr(b_addr), .sd_dqm(b_dqm), .init_done(b_done)
  );

  task automatic check(input string who, input string tag, input int cyc,
                       input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, who, cyc, act, exp);
    end
  endtask

  // expected schedule, computed from the requirements
  task automatic check_cycle(input string who, input int c, input bit in_rst,
                             input int w, input int t, input int f, input int rq,
                             input int mq, input logic [13:0] mode,
                             input logic [3:0] cmd, input logic [13:0] addr,
                             input logic cke, input logic [1:0] dqm, input logic done);
    int r, m, t_mrs, t_done, exp_cmd, exp_addr;
    string tag;
    r = (rq < 8) ? 8 : rq;
    m = (mq < 2) ? 2 : mq;
    t_mrs  = w + t + r * f;
    t_done = t_mrs + m;
    exp_cmd = 4'b0111; exp_addr = 0;
    if (in_rst) tag = "R1/R10";
    else if (c < w) tag = "R2";
    else if (c > t_done) tag = "R7";
    else tag = "R8";
    if (!in_rst) begin
      if (c == w) begin exp_cmd = 4'b0010; exp_addr = 1 << 10; tag = "R2"; end
      for (int i = 0; i < r; i++)
        if (c == w + t + i * f) begin
          exp_cmd = 4'b0001; tag = (i == 0) ? "R3" : "R4";
        end
      if (c == t_mrs) begin exp_cmd = 4'b0000; exp_addr = int'(mode); tag = "R5"; end
    end
    check(who, tag, c, int'(cmd), exp_cmd);
    check(who, tag, c, int'(addr), exp_addr);
    check(who, in_rst ? "R1" : ((c > t_done) ? "R7" : "R6"), c,
          int'(done), (!in_rst && c >= t_done) ? 1 : 0);
    check(who, "R9", c, int'({cke, dqm}), 3'b111);
  endtask

  task automatic sample(input int c, input bit in_rst);
    check_cycle("A", c, in_rst, A_W, A_T, A_F, A_R, A_M, mode_a,
                {a_cs, a_ras, a_cas, a_we}, a_addr, a_cke, a_dqm, a_done);
    check_cycle("B", c, in_rst, B_W, B_T, B_F, B_R, B_M, mode_b,
                {b_cs, b_ras, b_cas, b_we}, b_addr, b_cke, b_dqm, b_done);
  endtask

  // R10: every run starts from a fresh reset, possibly cutting the last one short
  task automatic run(input int ncyc, input logic [13:0] ma, input logic [13:0] mb);
    @(negedge clk);
    rst = 1'b1; mode_a = ma; mode_b = mb;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    sample(0, 1'b1);
    rst = 1'b0;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      sample(c, 1'b0);
    end
  endtask

  initial begin
    run(90, 14'h0032, 14'h3FFF);
    run(30, 14'h1555, 14'h0AAA);   // aborted mid-refresh
    run(90, 14'h2AAA, 14'h0001);
    run(90, 14'h0000, 14'h2233);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule